// File: doc/BRIEF.md
# Forward Parallel Port FIFO Strobe Engine

This block is the host half of a forward-only, compatibility-style parallel port. A DMA-style producer fills a small byte FIFO. The engine drains the FIFO one byte at a time. For each byte it:

- drives the byte on the data lines,
- waits a programmable setup time,
- pulls the strobe low for a programmable width,
- releases the strobe,
- keeps the byte on the lines for a programmable hold time.

Pacing comes only from the peripheral's Busy line, which passes through a flop synchronizer. The acknowledge line from the peripheral is never sampled. A byte therefore starts as soon as Busy reads low and the FIFO has data, with no wait for an acknowledge pulse. This lets the port approach the forward throughput limit of roughly one byte every 2 µs.

The time for one byte is setup + width + hold + 1 clock cycles when Busy stays low. With a 50 MHz clock, counts of 33 each give 100 cycles, which is 2 µs per byte. Each count is read as "at least one cycle", so a count of zero behaves like a count of one.

Top module: `fwd_strobe_engine`

## Requirements
- R1: After reset, `pp_strobe_n` is 1, `fifo_empty` is 1 and `wr_full` is 0.
- R2: Bytes written through `wr_data`/`wr_valid` appear on `pp_data` in write order. The byte is on `pp_data` at the cycle `pp_strobe_n` falls.
- R3: `pp_data` takes the new byte exactly max(`cfg_setup`,1) cycles before `pp_strobe_n` falls, and stays stable while the strobe is low.
- R4: `pp_strobe_n` stays low for exactly max(`cfg_width`,1) cycles.
- R5: After `pp_strobe_n` rises, `pp_data` is held for max(`cfg_hold`,1) cycles. When the next byte is already queued and Busy is low, that byte appears max(`cfg_hold`,1)+1 cycles after the rise.
- R6: No byte starts while the synchronized Busy is 1. When `pp_busy` goes low with a byte waiting, the byte appears on `pp_data` SYNC_STAGES+1 rising edges later.
- R7: `pp_ack_n` has no effect. Toggling it every cycle changes neither the transfer timing nor the start gating.
- R8: The FIFO holds FIFO_DEPTH bytes. `wr_full` is 1 once it holds FIFO_DEPTH bytes, and a write while full is dropped. `fifo_empty` is 1 once every byte has been sent.
- R9: Between transfers, `pp_strobe_n` rests at 1 and `pp_data` keeps the last byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W | Byte from the producer |
| wr_valid | input | 1 | Write strobe for `wr_data`; ignored when full |
| wr_full | output | 1 | FIFO holds FIFO_DEPTH bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| cfg_setup | input | CNT_W | Data-to-strobe setup cycles (0 treated as 1) |
| cfg_width | input | CNT_W | Strobe low cycles (0 treated as 1) |
| cfg_hold | input | CNT_W | Data hold cycles after strobe release (0 treated as 1) |
| pp_data | output | DATA_W | Parallel data lines |
| pp_strobe_n | output | 1 | Active-low data strobe |
| pp_busy | input | 1 | Peripheral busy, asynchronous |
| pp_ack_n | input | 1 | Peripheral acknowledge, unused by design |

## Verification
The bench builds the engine with DATA_W=8, FIFO_DEPTH=16, CNT_W=6 and SYNC_STAGES=2. With a 16-byte FIFO, the full flag and the dropped seventeenth write can be reached in a few dozen cycles. The small count width still covers zero counts and counts up to ten, so the minimum-of-one rule and longer phases are both measured. Two synchronizer stages make the Busy-release latency a fixed three edges, which the bench checks exactly.

// File: rtl/fse_pkg.sv
package fse_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_HOLD   = 2'd3
   } fse_state_e;

endpackage

// File: rtl/fse_sync.sv
module fse_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   // Reset to 1: the peripheral is treated as busy until a low is seen.
   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fse_fifo.sv
module fse_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_valid,
   input  logic          rd_pop,
   output logic [DW-1:0] rd_data,
   output logic          full,
   output logic          empty
);
   localparam int AW = $clog2(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   wr_ptr, rd_ptr;
   logic          do_wr, do_rd;

   assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign empty = (wr_ptr == rd_ptr);
   assign do_wr = wr_valid && !full;
   assign do_rd = rd_pop && !empty;
   assign rd_data = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/fse_fsm.sv
module fse_fsm
   import fse_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_empty,
   input  logic [DW-1:0] fifo_data,
   input  logic          busy_sync,
   input  logic [CW-1:0] cfg_setup,
   input  logic [CW-1:0] cfg_width,
   input  logic [CW-1:0] cfg_hold,
   output logic          fifo_pop,
   output logic [DW-1:0] pp_data,
   output logic          pp_strobe_n
);
   fse_state_e    state;
   logic [CW-1:0] cnt;
   logic          last_tick;

   // A phase ends when the counter holds 0 or 1, so every phase lasts at least one cycle.
   assign last_tick = (cnt[CW-1:1] == '0);
   assign fifo_pop  = (state == ST_IDLE) && !fifo_empty && !busy_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         pp_data     <= '0;
         pp_strobe_n <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (fifo_pop) begin
                  pp_data <= fifo_data;
                  cnt     <= cfg_setup;
                  state   <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (last_tick) begin
                  pp_strobe_n <= 1'b0;
                  cnt         <= cfg_width;
                  state       <= ST_STROBE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_STROBE: begin
               if (last_tick) begin
                  pp_strobe_n <= 1'b1;
                  cnt         <= cfg_hold;
                  state       <= ST_HOLD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               if (last_tick) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/fwd_strobe_engine.sv
module fwd_strobe_engine #(
   parameter int DATA_W      = 8,
   parameter int FIFO_DEPTH  = 16,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_valid,
   output logic              wr_full,
   output logic              fifo_empty,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_width,
   input  logic [CNT_W-1:0]  cfg_hold,
   output logic [DATA_W-1:0] pp_data,
   output logic              pp_strobe_n,
   input  logic              pp_busy,
   input  logic              pp_ack_n
);
   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be at least 1");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cw
         $error("CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              busy_sync;
   logic              fifo_pop;
   logic [DATA_W-1:0] fifo_head;
   logic              ack_unused;

   // The acknowledge line is deliberately left out of every decision.
   assign ack_unused = pp_ack_n;

   fse_sync #(.STAGES(SYNC_STAGES)) busy_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pp_busy),
      .q     (busy_sync)
   );

   fse_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_data),
      .wr_valid(wr_valid),
      .rd_pop  (fifo_pop),
      .rd_data (fifo_head),
      .full    (wr_full),
      .empty   (fifo_empty)
   );

   fse_fsm #(.DW(DATA_W), .CW(CNT_W)) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_empty (fifo_empty),
      .fifo_data  (fifo_head),
      .busy_sync  (busy_sync),
      .cfg_setup  (cfg_setup),
      .cfg_width  (cfg_width),
      .cfg_hold   (cfg_hold),
      .fifo_pop   (fifo_pop),
      .pp_data    (pp_data),
      .pp_strobe_n(pp_strobe_n)
   );
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_full,
   input logic              fifo_empty,
   input logic              fifo_pop,
   input logic              busy_sync,
   input logic [DATA_W-1:0] pp_data,
   input logic              pp_strobe_n
);
   // R8: full and empty never hold together
   p_full_empty_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_full && fifo_empty));

   // R8: a full FIFO stays full until a byte is taken out
   p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_full && !fifo_pop) |=> wr_full);

   // R6: a byte is taken only while synchronized Busy is low and data is queued
   p_start_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (!busy_sync && !fifo_empty));

   // R3: data does not move while the strobe is low
   p_data_stable_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pp_strobe_n |-> $stable(pp_data));

   // R5: data does not move on the strobe release edge
   p_data_hold_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pp_strobe_n) |-> $stable(pp_data));

   // R2: an empty FIFO is never popped
   p_no_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !fifo_pop);
endmodule

bind fwd_strobe_engine fse_checker #(.DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_full    (wr_full),
   .fifo_empty (fifo_empty),
   .fifo_pop   (fifo_pop),
   .busy_sync  (busy_sync),
   .pp_data    (pp_data),
   .pp_strobe_n(pp_strobe_n)
);

// File: tb/fwd_strobe_engine_tb_top.sv
`timescale 1ns/1ps
module fwd_strobe_engine_tb_top;
   localparam int DW = 8;
   localparam int CW = 6;
   localparam int DEPTH = 16;
   localparam int NVEC = 8;
   // [31:24] byte, [23:16] setup, [15:8] width, [7:0] hold
   localparam logic [31:0] VEC [0:NVEC-1] = '{
      32'hA5_01_01_01, 32'h3C_00_00_00, 32'hC3_05_02_03, 32'h7E_02_07_01,
      32'h81_03_03_00, 32'h19_0A_04_06, 32'hE6_01_09_02, 32'h5B_00_05_05
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic wr_valid = 1'b0;
   logic wr_full, fifo_empty;
   logic [CW-1:0] cfg_setup = 6'd1, cfg_width = 6'd1, cfg_hold = 6'd1;
   logic [DW-1:0] pp_data;
   logic pp_strobe_n;
   logic pp_busy = 1'b0;
   logic pp_ack_n = 1'b1;
   logic ack_wiggle = 1'b0;

   int checks = 0, fails = 0;
   int cyc = 0, t_chg = 0, t_fall = 0, t_rise = 0, n_fall = 0, n_rise = 0, cap_n = 0;
   logic [DW-1:0] cap [0:255];
   logic [DW-1:0] last_d = '0;
   logic last_s = 1'b1;

   always #10 clk = ~clk;

   fwd_strobe_engine #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_full(wr_full), .fifo_empty(fifo_empty),
      .cfg_setup(cfg_setup), .cfg_width(cfg_width), .cfg_hold(cfg_hold),
      .pp_data(pp_data), .pp_strobe_n(pp_strobe_n), .pp_busy(pp_busy), .pp_ack_n(pp_ack_n)
   );

   always @(negedge clk) pp_ack_n <= ack_wiggle ? ~pp_ack_n : 1'b1;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (pp_data !== last_d) begin t_chg = cyc; last_d = pp_data; end
      if (last_s && !pp_strobe_n) begin
         t_fall = cyc; cap[cap_n] = pp_data; cap_n = cap_n + 1; n_fall = n_fall + 1;
      end
      if (!last_s && pp_strobe_n) begin t_rise = cyc; n_rise = n_rise + 1; end
      last_s = pp_strobe_n;
   end

   function automatic int mx1(input int x);
      return (x < 1) ? 1 : x;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input logic [DW-1:0] b);
      @(negedge clk); wr_data = b; wr_valid = 1'b1;
      @(negedge clk); wr_valid = 1'b0;
   endtask

   task automatic wait_rises(input int target);
      int tmo;
      tmo = 0;
      while (n_rise < target && tmo < 2000) begin @(negedge clk); tmo++; end
   endtask

   task automatic wait_falls(input int target);
      int tmo;
      tmo = 0;
      while (n_fall < target && tmo < 2000) begin @(negedge clk); tmo++; end
   endtask

   task automatic set_cfg(input int s, input int w, input int h);
      cfg_setup = CW'(s); cfg_width = CW'(w); cfg_hold = CW'(h);
   endtask

   // One byte with full timing checks
   task automatic run_byte(input logic [DW-1:0] b, input int s, input int w, input int h);
      int r0;
      set_cfg(s, w, h);
      r0 = n_rise;
      push(b);
      wait_rises(r0 + 1);
      chk(cap[cap_n-1] == b, "R2 byte at strobe fall", cap[cap_n-1], b);
      chk(t_fall - t_chg == mx1(s), "R3 setup cycles", t_fall - t_chg, mx1(s));
      chk(t_rise - t_fall == mx1(w), "R4 strobe width", t_rise - t_fall, mx1(w));
      repeat (mx1(h) + 3) @(negedge clk);
      chk(pp_strobe_n == 1'b1 && pp_data == b, "R9 idle strobe high, data kept",
          {pp_strobe_n, pp_data}, {1'b1, b});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired (all R) actual=hang expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int base, tr, c0, f0;
      bit ok;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pp_strobe_n == 1'b1, "R1 strobe after reset", pp_strobe_n, 1);
      chk(fifo_empty == 1'b1 && wr_full == 1'b0, "R1 flags after reset",
          {fifo_empty, wr_full}, 2'b10);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // Vector table: R2, R3, R4, R9
      for (int i = 0; i < NVEC; i++) begin
         run_byte(VEC[i][31:24], int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
      end

      // R5 back-to-back hold, hold count 4 and hold count 0
      for (int k = 0; k < 2; k++) begin
         set_cfg(2, 3, (k == 0) ? 4 : 0);
         base = n_fall;
         push(8'h11 + 8'(k)); push(8'h22 + 8'(k));
         wait_rises(n_rise + 1);
         tr = t_rise;
         wait_falls(base + 2);
         chk(t_chg - tr == ((k == 0) ? 5 : 2), "R5 hold before next byte", t_chg - tr,
             (k == 0) ? 5 : 2);
         chk(cap[base] == 8'h11 + 8'(k) && cap[base+1] == 8'h22 + 8'(k),
             "R2 order of back-to-back bytes", cap[base+1], 8'h22 + 8'(k));
         wait_rises(n_rise + 1);
         repeat (8) @(negedge clk);
      end

      // R6 busy gating and release latency
      set_cfg(1, 1, 1);
      pp_busy = 1'b1;
      repeat (4) @(negedge clk);
      f0 = n_fall;
      push(8'h33);
      repeat (30) @(negedge clk);
      chk(n_fall == f0 && fifo_empty == 1'b0, "R6 no start while busy", n_fall - f0, 0);
      #1; pp_busy = 1'b0; c0 = cyc;
      wait_falls(f0 + 1);
      chk(t_chg - c0 == 3, "R6 start latency after busy release", t_chg - c0, 3);
      chk(cap[cap_n-1] == 8'h33, "R6 waiting byte sent", cap[cap_n-1], 8'h33);
      repeat (8) @(negedge clk);

      // R7 acknowledge toggling has no effect
      ack_wiggle = 1'b1;
      run_byte(8'h5A, 3, 2, 2);
      pp_busy = 1'b1;
      repeat (4) @(negedge clk);
      f0 = n_fall;
      push(8'h6B);
      repeat (20) @(negedge clk);
      chk(n_fall == f0, "R7 acknowledge does not start a byte", n_fall - f0, 0);
      pp_busy = 1'b0;
      wait_falls(f0 + 1);
      chk(cap[cap_n-1] == 8'h6B, "R7 byte after busy release", cap[cap_n-1], 8'h6B);
      ack_wiggle = 1'b0;
      repeat (10) @(negedge clk);

      // R8 FIFO depth, full flag, dropped write, empty at end
      set_cfg(1, 1, 1);
      pp_busy = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < DEPTH - 1; i++) push(8'h40 + 8'(i));
      chk(wr_full == 1'b0, "R8 not full one short of depth", wr_full, 0);
      push(8'h40 + 8'(DEPTH - 1));
      chk(wr_full == 1'b1, "R8 full at depth", wr_full, 1);
      push(8'hEE);
      base = n_fall;
      pp_busy = 1'b0;
      wait_falls(base + DEPTH);
      repeat (30) @(negedge clk);
      chk(n_fall - base == DEPTH, "R8 write while full dropped", n_fall - base, DEPTH);
      ok = 1'b1;
      for (int i = 0; i < DEPTH; i++) if (cap[base+i] != 8'h40 + 8'(i)) ok = 1'b0;
      chk(ok, "R8 queued bytes sent in order", ok, 1);
      chk(fifo_empty == 1'b1 && wr_full == 1'b0, "R8 empty after drain",
          {fifo_empty, wr_full}, 2'b10);
      chk(pp_strobe_n == 1'b1, "R9 strobe rests high after drain", pp_strobe_n, 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule